// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Register Window

This block is the register file of an interrupt redirection controller as software sees it. Software reaches it through two bus offsets. One is a select register that holds an 8-bit index. The other is a 32-bit data window that reads or writes whatever register the index points at. Behind the window are four kinds of register:

- a 4-bit controller identifier, plus an alias of it at another index;
- a read-only version word, which also reports how many entries exist;
- a table of redirection entries, 64 bits each, reached as two 32-bit halves.

The interrupt service engine sits beside the block. It reads every entry in parallel from a flat export bus. It also owns two status bits in each entry, remote-IRR and delivery status, and changes them through per-entry set and clear vectors. Bus writes cannot alter those two bits. Each accepted entry write raises a one-cycle `tableChanged` strobe, so the engine re-evaluates pending interrupts. Delivering interrupts and building message-signalled routes happen elsewhere.

Entry layout, which the service engine decodes:

| Bits | Field | Access |
|---|---|---|
| 7:0 | vector | read/write |
| 10:8 | delivery mode | read/write |
| 11 | destination mode | read/write |
| 12 | delivery status | read-only |
| 13 | polarity | read/write |
| 14 | remote-IRR | read-only |
| 15 | trigger (1 = level, 0 = edge) | read/write |
| 16 | mask | read/write |
| 63:56 | destination | read/write |

All other bits are reserved and read 0.

Top module: `irq_reg_window`

## Requirements
- R1: Only the low 8 bits of `busAddr` are decoded. Offset 0x00 is the select register and offset 0x10 is the data window. Reads of any other offset return 0, and writes to any other offset change nothing.
- R2: The select register accepts a write of any size and stores `busWrData[7:0]`. A read of it, at any size, returns that value zero-extended to 32 bits.
- R3: A data-window access whose `busSize` is not 4 is ignored. Such a write changes no state, and such a read returns 0.
- R4: Index 0 is the identifier register. A write stores `busWrData[27:24]`, and a read returns the stored value in bits 27:24 with every other bit 0. Index 2 reads the same value as index 0, and writes to index 2 are ignored.
- R5: Index 1 reads as VERSION ORed with (NUM_ENT−1) shifted left by 16, which is 0x0017_0020 at the default parameters. Writes to index 1 are ignored.
- R6: Index 0x10+2k reaches bits 31:0 of entry k, and index 0x11+2k reaches bits 63:32. Reserved bits read 0.
- R7: For indices 3 to 0x0F, and for indices at or above 0x10+2·NUM_ENT, a window read returns 0 and a window write changes nothing.
- R8: An entry write replaces only the addressed half. Bit 12 (delivery status) and bit 14 (remote-IRR) keep their previous values.
- R9: After an entry write, if bit 15 of the entry is 0 (edge), bit 14 is 0.
- R10: `tableChanged` is high for exactly the one cycle after each accepted entry write, and low at all other times.
- R11: `rirrSet[k]`/`rirrClr[k]` set or clear bit 14 of entry k, and `dsSet[k]`/`dsClr[k]` do the same for bit 12. Set wins over clear. The change is visible after the next clock edge. A bus write in the same cycle keeps these updated values, and R9 is then applied on top. Read/write bits change only through bus writes.
- R12: After reset, every entry reads 0x0000_0000_0001_0000 (masked, all other fields 0), the identifier is 0, the select register is 0 and `tableChanged` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Bus byte address; only the low 8 bits are decoded |
| busSize | input | 3 | Access size in bytes (1, 2 or 4) |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, valid in the same cycle as `busRdEn` |
| rirrSet | input | NUM_ENT | Per-entry remote-IRR set |
| rirrClr | input | NUM_ENT | Per-entry remote-IRR clear |
| dsSet | input | NUM_ENT | Per-entry delivery-status set |
| dsClr | input | NUM_ENT | Per-entry delivery-status clear |
| entryTable | output | 64·NUM_ENT | All entries; entry k is in bits 64k+63:64k |
| tableChanged | output | 1 | One-cycle pulse after an entry write |

## Verification
The bench attacks the following corner cases:

- **Read-only bits under write.** It writes the low half with bits 12 and 14 set while the service engine holds them in the opposite state. A design that lets the bus data through would hand control of those two bits to software.
- **Edge re-programming.** It re-programs an entry from level to edge while remote-IRR is set. A design that skips the forced clear would block every later level interrupt on that entry.
- **Index boundaries.** It probes the first and last entry indices, the first index past the table, and the gap between index 2 and 0x10. Off-by-one range logic shows up there as stray data or a corrupted neighbour.
- **Access size and address aliasing.** Narrow window accesses and aliased upper address bits catch a size check or decode that is missing.
- **Random traffic.** Random traffic, with service updates that collide with bus writes to the same entry, exposes a wrong order between merge and update.

// File: rtl/irw_pkg.sv
package irw_pkg;

  typedef enum logic [2:0] {
    RD_NONE = 3'd0,
    RD_SEL  = 3'd1,
    RD_ID   = 3'd2,
    RD_VER  = 3'd3,
    RD_ENT  = 3'd4
  } rdKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       selWr;
    logic       idWr;
    logic       entWr;
    logic       entHi;
    logic [7:0] entIdx;
    rdKind_e    rdKind;
  } ctrlStrb_t;

  localparam int DSTAT_BIT = 12;
  localparam int RIRR_BIT  = 14;
  localparam int TRIG_BIT  = 15;
  localparam int MASK_BIT  = 16;

  localparam logic [63:0] RW_MASK = 64'hFF00_0000_0001_AFFF;
  localparam logic [63:0] RO_MASK = 64'h0000_0000_0000_5000;
  localparam logic [63:0] ENT_RESET = 64'h0000_0000_0001_0000;

  localparam logic [7:0] IDX_ID   = 8'h00;
  localparam logic [7:0] IDX_VER  = 8'h01;
  localparam logic [7:0] IDX_ARB  = 8'h02;
  localparam logic [7:0] IDX_TBL  = 8'h10;

endpackage

// File: rtl/irw_ctrl.sv
module irw_ctrl
  import irw_pkg::*;
#(
  parameter int          NUM_ENT = 24,
  parameter logic [7:0]  SEL_OFF = 8'h00,
  parameter logic [7:0]  WIN_OFF = 8'h10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      offs,
  input  logic [2:0]      busSize,
  input  logic            busWrEn,
  input  logic            busRdEn,
  input  logic [7:0]      selReg,
  output ctrlStrb_t       strb
);

  localparam logic [7:0] NUM_ENT8 = 8'(NUM_ENT);

  logic       isSel;
  logic       isWin;
  logic [7:0] entRel;
  logic [7:0] entNum;
  logic       inTable;

  always_comb begin
    isSel   = (offs == SEL_OFF);
    isWin   = (offs == WIN_OFF) && (busSize == 3'd4);
    entRel  = selReg - IDX_TBL;
    entNum  = entRel >> 1;
    inTable = (selReg >= IDX_TBL) && (entNum < NUM_ENT8);
  end

  always_comb begin
    strb        = '0;
    strb.selWr  = busWrEn && isSel;
    strb.idWr   = busWrEn && isWin && (selReg == IDX_ID);
    strb.entWr  = busWrEn && isWin && inTable;
    strb.entHi  = selReg[0];
    strb.entIdx = entNum;
    strb.rdKind = RD_NONE;
    if (busRdEn) begin
      if (isSel) begin
        strb.rdKind = RD_SEL;
      end else if (isWin) begin
        if (selReg == IDX_ID || selReg == IDX_ARB) strb.rdKind = RD_ID;
        else if (selReg == IDX_VER)               strb.rdKind = RD_VER;
        else if (inTable)                         strb.rdKind = RD_ENT;
      end
    end
  end

  // R1: at most one write target per cycle
  p_onehot_wr_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selWr, strb.idWr, strb.entWr}));

  // R3: a narrow access never reaches window state
  p_narrow_win_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busSize != 3'd4) |-> (!strb.idWr && !strb.entWr && strb.rdKind != RD_ID
                           && strb.rdKind != RD_VER && strb.rdKind != RD_ENT));

  // R7: an entry write always targets an existing entry
  p_ent_range_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.entWr |-> (strb.entIdx < NUM_ENT8));

endmodule

// File: rtl/irw_entry.sv
module irw_entry
  import irw_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        wrHi,
  input  logic [31:0] wrData,
  input  logic        rirrSet,
  input  logic        rirrClr,
  input  logic        dsSet,
  input  logic        dsClr,
  output logic [63:0] entry
);

  logic [63:0] afterSvc;
  logic [63:0] merged;
  logic [63:0] nxt;

  always_comb begin
    afterSvc = entry;
    if (rirrClr) afterSvc[RIRR_BIT]  = 1'b0;
    if (rirrSet) afterSvc[RIRR_BIT]  = 1'b1;
    if (dsClr)   afterSvc[DSTAT_BIT] = 1'b0;
    if (dsSet)   afterSvc[DSTAT_BIT] = 1'b1;

    merged = wrHi ? {wrData, afterSvc[31:0]} : {afterSvc[63:32], wrData};

    nxt = afterSvc;
    if (wrEn) begin
      nxt = (merged & RW_MASK) | (afterSvc & RO_MASK);
      if (!nxt[TRIG_BIT]) nxt[RIRR_BIT] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) entry <= ENT_RESET;
    else       entry <= nxt;
  end

  // R9: edge entries leave a write with remote-IRR clear
  p_edge_rirr_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (entry[TRIG_BIT] || !entry[RIRR_BIT]));

  // R8: delivery status survives a bus write untouched by service
  p_ro_keep_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !dsSet && !dsClr) |=> $stable(entry[DSTAT_BIT]));

  // R11: read/write fields move only on bus writes
  p_rw_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ((entry & RW_MASK) == ($past(entry) & RW_MASK)));

  // R11: set has priority over clear
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rstN)
    rirrSet && !(wrEn) |=> entry[RIRR_BIT]);

endmodule

// File: rtl/irw_datapath.sv
module irw_datapath
  import irw_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int VERSION = 32'h20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic [31:0]           wrData,
  input  logic [NUM_ENT-1:0]    rirrSet,
  input  logic [NUM_ENT-1:0]    rirrClr,
  input  logic [NUM_ENT-1:0]    dsSet,
  input  logic [NUM_ENT-1:0]    dsClr,
  output logic [7:0]            selReg,
  output logic [31:0]           rdData,
  output logic [NUM_ENT*64-1:0] entryFlat,
  output logic                  tableChg
);

  localparam logic [31:0] VER_WORD = 32'(VERSION) | (32'(NUM_ENT - 1) << 16);

  logic [3:0]  idReg;
  logic [63:0] ent [NUM_ENT];
  logic [63:0] entSel;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selReg   <= '0;
      idReg    <= '0;
      tableChg <= 1'b0;
    end else begin
      if (strb.selWr) selReg <= wrData[7:0];
      if (strb.idWr)  idReg  <= wrData[27:24];
      tableChg <= strb.entWr;
    end
  end

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    irw_entry u_entry (
      .clk     (clk),
      .rstN    (rstN),
      .wrEn    (strb.entWr && (strb.entIdx == 8'(g))),
      .wrHi    (strb.entHi),
      .wrData  (wrData),
      .rirrSet (rirrSet[g]),
      .rirrClr (rirrClr[g]),
      .dsSet   (dsSet[g]),
      .dsClr   (dsClr[g]),
      .entry   (ent[g])
    );
    assign entryFlat[g*64 +: 64] = ent[g];
  end

  always_comb begin
    entSel = '0;
    for (int k = 0; k < NUM_ENT; k++) begin
      if (strb.entIdx == 8'(k)) entSel = ent[k];
    end
  end

  always_comb begin
    case (strb.rdKind)
      RD_SEL:  rdData = {24'h0, selReg};
      RD_ID:   rdData = {4'h0, idReg, 24'h0};
      RD_VER:  rdData = VER_WORD;
      RD_ENT:  rdData = strb.entHi ? entSel[63:32] : entSel[31:0];
      default: rdData = '0;
    endcase
  end

  // R4: identifier moves only on an index-0 write
  p_id_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.idWr |=> $stable(idReg));

  // R10: change strobe follows each entry write
  p_chg_pulse_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.entWr |=> tableChg);

  // R10: no strobe without a write
  p_chg_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.entWr |=> !tableChg);

  // R2: select register changes only on a select write
  p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selWr |=> $stable(selReg));

endmodule

// File: rtl/irq_reg_window.sv
module irq_reg_window
  import irw_pkg::*;
#(
  parameter int NUM_ENT = 24,
  parameter int ADDR_W  = 12,
  parameter int VERSION = 32'h20
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [2:0]            busSize,
  input  logic                  busWrEn,
  input  logic                  busRdEn,
  input  logic [31:0]           busWrData,
  output logic [31:0]           busRdData,
  input  logic [NUM_ENT-1:0]    rirrSet,
  input  logic [NUM_ENT-1:0]    rirrClr,
  input  logic [NUM_ENT-1:0]    dsSet,
  input  logic [NUM_ENT-1:0]    dsClr,
  output logic [NUM_ENT*64-1:0] entryTable,
  output logic                  tableChanged
);

  ctrlStrb_t  strb;
  logic [7:0] selReg;
  logic       unusedAddrHi;

  assign unusedAddrHi = ^busAddr[ADDR_W-1:8];

  irw_ctrl #(
    .NUM_ENT (NUM_ENT),
    .SEL_OFF (8'h00),
    .WIN_OFF (8'h10)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .offs    (busAddr[7:0]),
    .busSize (busSize),
    .busWrEn (busWrEn),
    .busRdEn (busRdEn),
    .selReg  (selReg),
    .strb    (strb)
  );

  irw_datapath #(
    .NUM_ENT (NUM_ENT),
    .VERSION (VERSION)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrData    (busWrData),
    .rirrSet   (rirrSet),
    .rirrClr   (rirrClr),
    .dsSet     (dsSet),
    .dsClr     (dsClr),
    .selReg    (selReg),
    .rdData    (busRdData),
    .entryFlat (entryTable),
    .tableChg  (tableChanged)
  );

  // R3: narrow window reads return zero
  p_narrow_rd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr[7:0] == 8'h10 && busSize != 3'd4) |-> (busRdData == 32'h0));

  // R1: unmapped offsets read zero
  p_unmapped_rd_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr[7:0] != 8'h10 && busAddr[7:0] != 8'h00) |-> (busRdData == 32'h0));

endmodule

// File: tb/irq_reg_window_tb.sv
module irq_reg_window_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM = 24;
  localparam int AW  = 12;
  localparam logic [63:0] RW  = 64'hFF00_0000_0001_AFFF;
  localparam logic [63:0] RO  = 64'h0000_0000_0000_5000;

  logic clk = 0;
  logic rstN = 0;
  logic [AW-1:0] busAddr = '0;
  logic [2:0] busSize = 3'd4;
  logic busWrEn = 0, busRdEn = 0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NUM-1:0] rirrSet = '0, rirrClr = '0, dsSet = '0, dsClr = '0;
  logic [NUM*64-1:0] entryTable;
  logic tableChanged;

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [63:0] mEnt [NUM];
  logic [3:0]  mId;
  logic [7:0]  mSel;
  logic        mChg;
  logic        started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_reg_window #(.NUM_ENT(NUM), .ADDR_W(AW), .VERSION(32'h20)) u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busSize(busSize),
    .busWrEn(busWrEn), .busRdEn(busRdEn), .busWrData(busWrData),
    .busRdData(busRdData), .rirrSet(rirrSet), .rirrClr(rirrClr),
    .dsSet(dsSet), .dsClr(dsClr), .entryTable(entryTable),
    .tableChanged(tableChanged)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: what a read should return now
  function automatic logic [31:0] refRead();
    int e;
    if (!busRdEn) return 32'h0;
    if (busAddr[7:0] == 8'h00) return {24'h0, mSel};
    if (busAddr[7:0] != 8'h10 || busSize != 3'd4) return 32'h0;
    if (mSel == 8'h00 || mSel == 8'h02) return {4'h0, mId, 24'h0};
    if (mSel == 8'h01) return 32'h0017_0020;
    if (mSel < 8'h10) return 32'h0;
    e = (int'(mSel) - 16) / 2;
    if (e >= NUM) return 32'h0;
    return mSel[0] ? mEnt[e][63:32] : mEnt[e][31:0];
  endfunction

  // model update on each edge
  always @(posedge clk) begin
    logic wrote;
    wrote = 0;
    if (!rstN) begin
      for (int k = 0; k < NUM; k++) mEnt[k] = 64'h1_0000;
      mId = 0; mSel = 0;
    end else begin
      for (int k = 0; k < NUM; k++) begin
        if (rirrClr[k]) mEnt[k][14] = 0;
        if (rirrSet[k]) mEnt[k][14] = 1;
        if (dsClr[k])   mEnt[k][12] = 0;
        if (dsSet[k])   mEnt[k][12] = 1;
      end
      if (busWrEn) begin
        if (busAddr[7:0] == 8'h00) mSel = busWrData[7:0];
        else if (busAddr[7:0] == 8'h10 && busSize == 3'd4) begin
          if (mSel == 8'h00) mId = busWrData[27:24];
          else if (mSel >= 8'h10 && (int'(mSel) - 16) / 2 < NUM) begin
            int e;
            logic [63:0] n;
            e = (int'(mSel) - 16) / 2;
            n = mEnt[e];
            if (mSel[0]) n[63:32] = busWrData; else n[31:0] = busWrData;
            n = (n & RW) | (mEnt[e] & RO);
            if (!n[15]) n[14] = 0;
            mEnt[e] = n;
            wrote = 1;
          end
        end
      end
    end
    mChg = wrote;
    started = 1;
  end

  // compare registered outputs every cycle (R8 R9 R10 R11)
  always @(negedge clk) begin
    if (started && rstN) begin
      logic [NUM*64-1:0] flat;
      for (int k = 0; k < NUM; k++) flat[k*64 +: 64] = mEnt[k];
      checks++;
      if (entryTable !== flat) begin
        fails++;
        for (int k = 0; k < NUM; k++)
          if (entryTable[k*64 +: 64] !== mEnt[k])
            $display("FAIL R8/R9/R11 entry %0d actual=%h expected=%h at %0t",
                     k, entryTable[k*64 +: 64], mEnt[k], $time);
      end
      check("R10 tableChanged", {63'h0, tableChanged}, {63'h0, mChg});
    end
  end

  task automatic op(input logic wr, input logic rd, input logic [AW-1:0] a,
                    input logic [2:0] sz, input logic [31:0] d, input string tag);
    @(negedge clk);
    busWrEn = wr; busRdEn = rd; busAddr = a; busSize = sz; busWrData = d;
    #1;
    if (rd) check(tag, {32'h0, busRdData}, {32'h0, refRead()});
    @(posedge clk); #1;
    busWrEn = 0; busRdEn = 0; rirrSet = '0; rirrClr = '0; dsSet = '0; dsClr = '0;
  endtask

  task automatic rdIdx(input logic [7:0] idx, input logic [31:0] exp, input string tag);
    op(1, 0, 12'h000, 3'd1, {24'h0, idx}, tag);
    op(0, 1, 12'h010, 3'd4, 32'h0, tag);
    @(negedge clk); busRdEn = 1; busAddr = 12'h010; busSize = 3'd4; #1;
    check(tag, {32'h0, busRdData}, {32'h0, exp});
    @(posedge clk); #1; busRdEn = 0;
  endtask

  task automatic wrIdx(input logic [7:0] idx, input logic [31:0] d, input string tag);
    op(1, 0, 12'h000, 3'd4, {24'h0, idx}, tag);
    op(1, 0, 12'h010, 3'd4, d, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R12 reset state
    for (int k = 0; k < NUM; k++)
      check("R12 reset entry", entryTable[k*64 +: 64], 64'h0000_0000_0001_0000);
    check("R12 reset chg", {63'h0, tableChanged}, 64'h0);
    rdIdx(8'h00, 32'h0, "R12 reset id");
    op(0, 1, 12'h000, 3'd4, 0, "R12 reset sel");

    // R5 version and ignored write
    rdIdx(8'h01, 32'h0017_0020, "R5 version");
    wrIdx(8'h01, 32'hFFFF_FFFF, "R5 ver write");
    rdIdx(8'h01, 32'h0017_0020, "R5 version after write");

    // R4 identifier and alias
    wrIdx(8'h00, 32'hA5FF_FFFF, "R4 id write");
    rdIdx(8'h00, 32'h0500_0000, "R4 id read");
    rdIdx(8'h02, 32'h0500_0000, "R4 arb alias");
    wrIdx(8'h02, 32'h0C00_0000, "R4 arb write");
    rdIdx(8'h00, 32'h0500_0000, "R4 id after arb write");

    // R2 select register sizes
    op(1, 0, 12'h000, 3'd1, 32'hFFFF_FF3C, "R2 sel write b");
    op(0, 1, 12'h000, 3'd2, 0, "R2 sel read h");
    check("R2 sel value", {56'h0, mSel}, 64'h3C);

    // R6 entry halves, first and last
    wrIdx(8'h10, 32'h0000_8123, "R6 ent0 lo");
    wrIdx(8'h11, 32'hAB00_0000, "R6 ent0 hi");
    rdIdx(8'h10, 32'h0000_8123, "R6 ent0 lo read");
    rdIdx(8'h11, 32'hAB00_0000, "R6 ent0 hi read");
    wrIdx(8'h3F, 32'hFFFF_FFFF, "R6 last hi");
    rdIdx(8'h3F, 32'hFF00_0000, "R6 last hi reserved");
    rdIdx(8'h3E, 32'h0001_0000, "R8 last lo untouched");

    // R7 out of range and gap
    wrIdx(8'h40, 32'hFFFF_FFFF, "R7 past end write");
    rdIdx(8'h40, 32'h0, "R7 past end read");
    rdIdx(8'h05, 32'h0, "R7 gap read");

    // R3 narrow window
    op(1, 0, 12'h000, 3'd4, 32'h10, "R3 sel");
    op(1, 0, 12'h010, 3'd2, 32'h0000_00FF, "R3 narrow write");
    op(0, 1, 12'h010, 3'd1, 0, "R3 narrow read");
    rdIdx(8'h10, 32'h0000_8123, "R3 entry unchanged");

    // R1 decode of low byte only and unmapped offsets
    op(1, 0, 12'hF00, 3'd4, 32'h12, "R1 alias sel");
    op(0, 1, 12'h710, 3'd4, 0, "R1 alias window read");
    op(1, 0, 12'h020, 3'd4, 32'h77, "R1 unmapped write");
    op(0, 1, 12'h020, 3'd4, 0, "R1 unmapped read");
    op(0, 1, 12'h000, 3'd4, 0, "R1 sel after unmapped");

    // R11/R8 service updates and read-only bits (entry 1 is level)
    wrIdx(8'h12, 32'h0000_8040, "R8 ent1 level");
    @(negedge clk); rirrSet[1] = 1; dsSet[1] = 1; rirrClr[1] = 1;
    @(posedge clk); #1; rirrSet = '0; dsSet = '0; rirrClr = '0;
    rdIdx(8'h12, 32'h0000_D040, "R11 set wins");
    wrIdx(8'h12, 32'h0000_8041, "R8 write keeps ro");
    rdIdx(8'h12, 32'h0000_D041, "R8 ro kept");
    // R9 level to edge clears remote-IRR
    wrIdx(8'h12, 32'h0000_5042, "R9 to edge");
    rdIdx(8'h12, 32'h0000_1042, "R9 rirr cleared");

    // random traffic with colliding service updates
    for (int i = 0; i < 600; i++) begin
      logic [7:0] idx;
      idx = 8'($urandom_range(0, 70));
      op(1, 0, 12'($urandom_range(0, 15) << 8), 3'd4, {24'h0, idx}, "R2 rand sel");
      @(negedge clk);
      busAddr = ($urandom_range(0, 9) == 0) ? 12'h030 : 12'h010;
      busSize = ($urandom_range(0, 7) == 0) ? 3'd2 : 3'd4;
      busWrEn = $urandom_range(0, 1);
      busRdEn = !busWrEn;
      busWrData = $urandom;
      rirrSet = NUM'($urandom & $urandom & $urandom);
      rirrClr = NUM'($urandom & $urandom);
      dsSet = NUM'($urandom & $urandom & $urandom);
      dsClr = NUM'($urandom & $urandom);
      #1;
      if (busRdEn) check("R6 rand read", {32'h0, busRdData}, {32'h0, refRead()});
      @(posedge clk); #1;
      busWrEn = 0; busRdEn = 0; rirrSet = '0; rirrClr = '0; dsSet = '0; dsClr = '0;
    end

    repeat (2) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule